// File: doc/BRIEF.md
# Loop decoded-instruction buffer controller

This block sits between an instruction decoder and the execute stage of a processor. It serves hardware loops with a fixed body length. A loop-start command gives the number of body entries and the total number of iterations. During the first iteration the decoder drives the execute stage as usual, and the controller also writes each accepted decoded control word into a small local buffer, in program order.

On every later iteration the controller plays those stored words back to the execute stage. While it does so it drops the fetch and decode enables, so the front of the pipeline sits idle. The stored words are used again on each pass and are never rewritten. When the last transfer of the last iteration completes, the controller gives a one-cycle completion pulse. The decoder then drives the execute stage again, and fetch and decode run once more.

The execute stage can stall the controller through a ready input. A control word counts as transferred only in a cycle where it is valid and ready is high.

Top module: `loop_dib_ctrl`

## Requirements
- R1: Synchronous active-low reset returns the controller to the idle state. It clears the pointers and the iteration counter and sets `loop_done` low. From the first cycle after reset, `fetch_en` and `decode_en` are high and the output passes the decoder through.
- R2: When idle, `ex_word` equals `dec_word` and `ex_valid` equals `dec_valid` in the same cycle, with both enables high.
- R3: A start command (`start_valid` high) is accepted only when the controller is idle and `start_iters` is nonzero. `start_len_m1` holds the body length minus one, so 0 means 1 entry and DEPTH-1 means DEPTH entries. A start with `start_iters` = 0 is ignored.
- R4: In the first iteration the decoder is passed through with both enables high. Each word with `dec_valid` and `ex_ready` both high is stored in the next buffer entry, starting at entry 0.
- R5: In later iterations `fetch_en` and `decode_en` are low and `ex_valid` is high. `ex_word` presents the stored words in order from entry 0 to the last entry, and then wraps back to entry 0.
- R6: While the stored words are being played back, `dec_word` and `dec_valid` have no effect on `ex_word`, and the stored entries are not rewritten.
- R7: While `ex_ready` is low, the capture and playback positions hold and `ex_word` stays stable.
- R8: With an iteration count N of 2 or more, the controller performs one capture pass and N-1 playback passes. In the cycle after the final transfer, `loop_done` is high for exactly one cycle, the controller is idle again, and both enables are high.
- R9: With an iteration count of 1, the controller captures one pass and never plays back. The enables stay high throughout, and `loop_done` pulses in the cycle after the last captured word.
- R10: A start command that arrives while a loop is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | Loop-start command strobe |
| start_len_m1 | input | PTR_W (4) | Loop body length minus one |
| start_iters | input | CNT_W (16) | Total iteration count |
| dec_valid | input | 1 | Decoder word valid |
| dec_word | input | CW_W (32) | Decoded control word from the decoder |
| ex_ready | input | 1 | Execute stage accepts the current word |
| fetch_en | output | 1 | Instruction fetch enable |
| decode_en | output | 1 | Instruction decode enable |
| ex_valid | output | 1 | Execute-stage control word valid |
| ex_word | output | CW_W (32) | Selected control word for the execute stage |
| loop_done | output | 1 | One-cycle pulse when a loop finishes |

## Verification
If the playback pointer is corrupted, the wrong stored word reaches `ex_word` in the very next playback cycle. The bench therefore compares every playback cycle against the words it sent during capture. If the iteration counter is wrong, `loop_done` rises early or late and the enables come back at the wrong edge. This shows up within one body length of the fault, and the bench checks the exact cycle of the pulse. A stray write, or a start accepted while the controller is busy, shows up as a corrupted word or a shifted loop on a later pass. A reset that fails to clear state shows up as low enables or a stale word in the first cycle after reset.

// File: rtl/dib_pkg.sv
// Shared types for the loop decoded-instruction buffer controller.
// Assumes: nothing beyond the enum below.
package dib_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_REPLAY  = 2'd2
    } dib_state_e;

endpackage

// File: rtl/dib_store.sv
// Decoded-word storage. It has one write port and one combinational read port.
// Assumes: DEPTH is a power of two. The data entries carry no reset,
// because every entry is written before it is read.
module dib_store #(
    parameter int CW_W  = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [CW_W-1:0]  wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [CW_W-1:0]  rdata
);

    logic [CW_W-1:0]  mem [DEPTH];
    logic [DEPTH-1:0] hit;

    // One write-select line for each entry.
    for (genvar e = 0; e < DEPTH; e++) begin : g_sel
        assign hit[e] = we && (waddr == PTR_W'(e));
    end

    // Write the selected entry.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (hit[e]) mem[e] <= wdata;
        end
    end

    // Read the addressed entry.
    assign rdata = mem[raddr];

endmodule

// File: rtl/dib_seq.sv
// Loop sequencer. It holds the state machine, the capture and playback
// pointers, and the iteration counter.
// Assumes: start_len_m1 < DEPTH, and a transfer needs ready high
// (together with dec_valid during capture).
module dib_seq
    import dib_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [PTR_W-1:0] start_len_m1,
    input  logic [CNT_W-1:0] start_iters,
    input  logic             dec_valid,
    input  logic             ex_ready,
    output dib_state_e       state_o,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             loop_done
);

    dib_state_e       state_q;
    logic [PTR_W-1:0] last_q;
    logic [CNT_W-1:0] iter_q;
    logic             start_ok, cap_fire, rep_fire, cap_last, rep_wrap, final_xfer;

    // Transfer and wrap qualifiers.
    always_comb begin
        start_ok   = (state_q == ST_IDLE) && start_valid && (start_iters != '0);
        cap_fire   = (state_q == ST_CAPTURE) && dec_valid && ex_ready;
        rep_fire   = (state_q == ST_REPLAY) && ex_ready;
        cap_last   = cap_fire && (wr_ptr == last_q);
        rep_wrap   = rep_fire && (rd_ptr == last_q);
        final_xfer = (cap_last || rep_wrap) && (iter_q == CNT_W'(1));
    end

    // State transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start_ok) state_q <= ST_CAPTURE;
                ST_CAPTURE: if (cap_last) state_q <= final_xfer ? ST_IDLE : ST_REPLAY;
                ST_REPLAY:  if (final_xfer) state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the body length when a loop starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= '0;
        else if (start_ok) last_q <= start_len_m1;
    end

    // Capture write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) wr_ptr <= '0;
        else if (cap_fire)      wr_ptr <= cap_last ? '0 : wr_ptr + 1'b1;
    end

    // Playback read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) rd_ptr <= '0;
        else if (rep_fire)      rd_ptr <= rep_wrap ? '0 : rd_ptr + 1'b1;
    end

    // Remaining iterations; one is taken off at the end of each pass.
    always_ff @(posedge clk) begin
        if (!rst_n)                    iter_q <= '0;
        else if (start_ok)             iter_q <= start_iters;
        else if (cap_last || rep_wrap) iter_q <= iter_q - 1'b1;
    end

    // Completion pulse in the cycle after the final transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) loop_done <= 1'b0;
        else        loop_done <= final_xfer;
    end

    assign state_o = state_q;
    assign wr_en   = cap_fire;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |=> !loop_done);                                        // R8
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> (state_q == ST_IDLE));                              // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY && !ex_ready) |=> (rd_ptr == $past(rd_ptr))); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && !(dec_valid && ex_ready)) |=> (wr_ptr == $past(wr_ptr))); // R7
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_valid) |=> (last_q == $past(last_q))); // R10
    AST_ITER_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY && !rep_wrap) |=> (iter_q == $past(iter_q))); // R8
    AST_ONE_ITER_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && iter_q == CNT_W'(1)) |=> (state_q != ST_REPLAY)); // R9

endmodule

// File: rtl/dib_select.sv
// Execute-stage selector. It picks the live decoder word or the stored
// word, and drives the front-end enables.
// Assumes: the state comes from dib_seq and the stored word from dib_store.
module dib_select
    import dib_pkg::*;
#(
    parameter int CW_W = 32
) (
    input  dib_state_e      state,
    input  logic            dec_valid,
    input  logic [CW_W-1:0] dec_word,
    input  logic [CW_W-1:0] buf_word,
    output logic            ex_valid,
    output logic [CW_W-1:0] ex_word,
    output logic            fetch_en,
    output logic            decode_en
);

    logic use_buf;

    // Pick the source and gate the front end.
    always_comb begin
        use_buf   = (state == ST_REPLAY);
        ex_word   = use_buf ? buf_word : dec_word;
        ex_valid  = use_buf ? 1'b1 : dec_valid;
        fetch_en  = !use_buf;
        decode_en = !use_buf;
    end

endmodule

// File: rtl/loop_dib_ctrl.sv
// Loop decoded-instruction buffer controller, top level. It captures the
// loop body on the first pass, plays it back on later passes and idles
// the fetch and decode stages during playback.
// Assumes: DEPTH is a power of two; loops are neither nested nor
// branched out of.
module loop_dib_ctrl
    import dib_pkg::*;
#(
    parameter int CW_W  = 32,
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [PTR_W-1:0] start_len_m1,
    input  logic [CNT_W-1:0] start_iters,
    input  logic             dec_valid,
    input  logic [CW_W-1:0]  dec_word,
    input  logic             ex_ready,
    output logic             fetch_en,
    output logic             decode_en,
    output logic             ex_valid,
    output logic [CW_W-1:0]  ex_word,
    output logic             loop_done
);

    dib_state_e       state;
    logic             buf_we;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CW_W-1:0]  buf_word;

    dib_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_len_m1(start_len_m1), .start_iters(start_iters),
        .dec_valid(dec_valid), .ex_ready(ex_ready), .state_o(state),
        .wr_en(buf_we), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .loop_done(loop_done)
    );

    dib_store #(.CW_W(CW_W), .DEPTH(DEPTH)) i_store (
        .clk(clk), .we(buf_we), .waddr(wr_ptr), .wdata(dec_word),
        .raddr(rd_ptr), .rdata(buf_word)
    );

    dib_select #(.CW_W(CW_W)) i_select (
        .state(state), .dec_valid(dec_valid), .dec_word(dec_word),
        .buf_word(buf_word), .ex_valid(ex_valid), .ex_word(ex_word),
        .fetch_en(fetch_en), .decode_en(decode_en)
    );

    AST_NO_WRITE_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY) |-> !buf_we);                                // R6
    AST_STALL_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY && !ex_ready) |=> (state != ST_REPLAY || $stable(ex_word))); // R7

endmodule

// File: tb/test_loop_dib_ctrl.sv
// Bench for loop_dib_ctrl. A vector table is walked first, followed by
// directed tests.
module test_loop_dib_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CW_W = 32, DEPTH = 16, CNT_W = 16, PTR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_valid = 1'b0;
    logic [PTR_W-1:0] start_len_m1 = '0;
    logic [CNT_W-1:0] start_iters = '0;
    logic             dec_valid = 1'b0;
    logic [CW_W-1:0]  dec_word = '0;
    logic             ex_ready = 1'b0;
    logic             fetch_en, decode_en, ex_valid, loop_done;
    logic [CW_W-1:0]  ex_word;

    int checks = 0, failures = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_dib_ctrl #(.CW_W(CW_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_loop_dib_ctrl (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_len_m1(start_len_m1), .start_iters(start_iters),
        .dec_valid(dec_valid), .dec_word(dec_word), .ex_ready(ex_ready),
        .fetch_en(fetch_en), .decode_en(decode_en), .ex_valid(ex_valid),
        .ex_word(ex_word), .loop_done(loop_done)
    );

    typedef struct packed {
        logic             st;
        logic [PTR_W-1:0] lm1;
        logic [CNT_W-1:0] it;
        logic             dv;
        logic [CW_W-1:0]  dw;
        logic             rdy;
        logic             efen;
        logic             eev;
        logic [CW_W-1:0]  eew;
        logic             edone;
    } vec_t;

    localparam logic [CW_W-1:0] A1 = 32'h1111_0001, A2 = 32'h2222_0002,
        A3 = 32'h3333_0003, BAD = 32'hBAD0_BAD0, C1 = 32'hC1C1_0000, C2 = 32'hC2C2_0000;

    // Loop of 3 entries run 3 times, with stalls, a decoder bubble and a start sent while busy.
    localparam vec_t VEC [15] = '{
        '{1'b1, 4'd2, 16'd3, 1'b0, 32'h0,       1'b1, 1'b1, 1'b0, 32'h0,       1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, A1,          1'b1, 1'b1, 1'b1, A1,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, A2,          1'b0, 1'b1, 1'b1, A2,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, A2,          1'b1, 1'b1, 1'b1, A2,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b0, 32'hFF,      1'b1, 1'b1, 1'b0, 32'hFF,      1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, A3,          1'b1, 1'b1, 1'b1, A3,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, BAD,         1'b1, 1'b0, 1'b1, A1,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, BAD,         1'b1, 1'b0, 1'b1, A2,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b0, 32'h0,       1'b0, 1'b0, 1'b1, A3,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b0, 32'h0,       1'b1, 1'b0, 1'b1, A3,          1'b0},
        '{1'b1, 4'd0, 16'd5, 1'b0, 32'h0,       1'b1, 1'b0, 1'b1, A1,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b0, 32'h0,       1'b1, 1'b0, 1'b1, A2,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b0, 32'h0,       1'b1, 1'b0, 1'b1, A3,          1'b0},
        '{1'b0, 4'd0, 16'd0, 1'b1, C1,          1'b1, 1'b1, 1'b1, C1,          1'b1},
        '{1'b0, 4'd0, 16'd0, 1'b1, C2,          1'b1, 1'b1, 1'b1, C2,          1'b0}
    };

    function automatic string row_req(input int i);
        case (i)
            0:          return "R3";
            1, 3, 5:    return "R4";
            2, 8:       return "R7";
            4, 14:      return "R2";
            6:          return "R6";
            10:         return "R10";
            13:         return "R8";
            default:    return "R5";
        endcase
    endfunction

    task automatic chk(input string req, input logic efen, input logic eev,
                       input logic [CW_W-1:0] eew, input logic edone);
        checks++;
        if (fetch_en !== efen || decode_en !== efen || ex_valid !== eev ||
            ex_word !== eew || loop_done !== edone) begin
            failures++;
            $display("FAIL %s: got fen=%b den=%b ev=%b ew=%h done=%b exp fen=%b ev=%b ew=%h done=%b",
                     req, fetch_en, decode_en, ex_valid, ex_word, loop_done,
                     efen, eev, eew, edone);
        end
    endtask

    // Apply one cycle of stimulus after a falling edge and let it settle.
    task automatic drive(input logic st, input logic [PTR_W-1:0] lm1, input logic [CNT_W-1:0] it,
                         input logic dv, input logic [CW_W-1:0] dw, input logic rdy);
        @(negedge clk);
        start_valid = st; start_len_m1 = lm1; start_iters = it;
        dec_valid = dv; dec_word = dw; ex_ready = rdy;
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog: got cycles=%0d exp <=5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", 1'b1, 1'b0, 32'h0, 1'b0);

        // Vector table.
        for (int i = 0; i < 15; i++) begin
            drive(VEC[i].st, VEC[i].lm1, VEC[i].it, VEC[i].dv, VEC[i].dw, VEC[i].rdy);
            chk(row_req(i), VEC[i].efen, VEC[i].eev, VEC[i].eew, VEC[i].edone);
        end

        // R3: a start with zero iterations is ignored.
        drive(1'b1, 4'd0, 16'd0, 1'b0, 32'h0, 1'b1);
        drive(1'b0, 4'd0, 16'd0, 1'b1, 32'h55, 1'b1);
        chk("R3", 1'b1, 1'b1, 32'h55, 1'b0);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h56, 1'b1);
        chk("R3", 1'b1, 1'b0, 32'h56, 1'b0);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h57, 1'b1);
        chk("R3", 1'b1, 1'b0, 32'h57, 1'b0);

        // R9: a single iteration captures only.
        drive(1'b1, 4'd1, 16'd1, 1'b0, 32'h0, 1'b1);
        drive(1'b0, 4'd0, 16'd0, 1'b1, 32'h901, 1'b1);
        chk("R9", 1'b1, 1'b1, 32'h901, 1'b0);
        drive(1'b0, 4'd0, 16'd0, 1'b1, 32'h902, 1'b1);
        chk("R9", 1'b1, 1'b1, 32'h902, 1'b0);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h903, 1'b1);
        chk("R9", 1'b1, 1'b0, 32'h903, 1'b1);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h904, 1'b1);
        chk("R9", 1'b1, 1'b0, 32'h904, 1'b0);

        // R5: a body of full depth, two iterations.
        drive(1'b1, 4'd15, 16'd2, 1'b0, 32'h0, 1'b1);
        for (int k = 0; k < DEPTH; k++) begin
            drive(1'b0, 4'd0, 16'd0, 1'b1, 32'h100 + k, 1'b1);
            chk("R4", 1'b1, 1'b1, 32'h100 + k, 1'b0);
        end
        for (int k = 0; k < DEPTH; k++) begin
            drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h0, 1'b1);
            chk("R5", 1'b0, 1'b1, 32'h100 + k, 1'b0);
        end
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h0, 1'b1);
        chk("R8", 1'b1, 1'b0, 32'h0, 1'b1);

        // R1: reset in the middle of playback.
        drive(1'b1, 4'd0, 16'd5, 1'b0, 32'h0, 1'b1);
        drive(1'b0, 4'd0, 16'd0, 1'b1, 32'hDEAD, 1'b1);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h0, 1'b1);
        chk("R5", 1'b0, 1'b1, 32'hDEAD, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 4'd0, 16'd0, 1'b1, 32'h77, 1'b1);
        rst_n = 1'b1;
        #1;
        chk("R1", 1'b1, 1'b1, 32'h77, 1'b0);
        drive(1'b0, 4'd0, 16'd0, 1'b0, 32'h78, 1'b1);
        chk("R1", 1'b1, 1'b0, 32'h78, 1'b0);

        finish_run();
    end

endmodule